// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block translates a guest virtual address into a machine physical address for a virtualized processor. Two page tables are involved. The guest table maps guest virtual to guest physical. The host table maps guest physical to machine physical. Every guest-physical address the walk needs must pass through a full host-table walk before the walker can use it: the guest root, the guest second-level table pointer and the final guest frame. A translation with no fault therefore costs eight memory reads. The walker sends them one at a time over a simple read port. That port may take any number of cycles to return data.

Each request returns one of three outcomes. The first is a machine address. The second is a guest-level fault, which the guest kernel services without an exit to the hypervisor. The third is a host-level fault, which requires a hypervisor exit. The response also reports how many reads the translation used, so the caller can account for the cost of the walk.

The walker is a single state machine with these states: `WS_IDLE` (waits for a request), `WS_HOST_L1_REQ` / `WS_HOST_L1_WAIT` (first-level host entry), `WS_HOST_L2_REQ` / `WS_HOST_L2_WAIT` (second-level host entry), `WS_GUEST_REQ` / `WS_GUEST_WAIT` (guest entry at the current guest level) and `WS_RESPOND` (one-cycle response). Its transitions are:
- IDLE to HOST_L1_REQ when a request is accepted.
- Each REQ state to its WAIT state when the memory port is ready.
- HOST_L1_WAIT to HOST_L2_REQ when the entry is present.
- HOST_L2_WAIT to GUEST_REQ when the entry is present and the walk is on the root or the pointer.
- HOST_L2_WAIT to RESPOND when the entry is present and the walk is on the final frame.
- GUEST_WAIT to HOST_L1_REQ when the entry is present.
- Any WAIT state to RESPOND when the entry is not present.
- RESPOND to IDLE.

Top module: `nested_walker`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is accepted when `req_valid` and `req_ready` are both high. While a translation is in progress, any request presented is ignored, up to and including its response cycle.
- R2: A table entry is 32 bits. Bit 0 set means present. Bits 31:12 hold the frame number. An entry with bit 0 clear is not present, whatever its frame bits hold. The entry address is the table frame shifted left by 12, plus the index times 4. The guest virtual address splits into a first-level index in bits 31:22, a second-level index in bits 21:12 and an offset in bits 11:0.
- R3: A host walk of a guest-physical address G does two reads. The first reads the host root table at index G[31:22]. The second reads the table named by that entry, at index G[21:12].
- R4: Reads occur in this fixed order: host walk of the guest root, guest first-level entry, host walk of that entry's frame, guest second-level entry, host walk of the final guest frame. The ordering stops at the first fault.
- R5: A translation with no fault responds with status 0. The address is the machine frame from the last host walk joined with the virtual address bits 11:0, and the read count is 8.
- R6: A guest entry that is not present gives status 1. The address is the original guest virtual address. The read count is 3 for a first-level miss and 6 for a second-level miss.
- R7: A host entry that is not present gives status 2. The address is the guest-physical address being translated: the guest root value, the table pointer frame with a zero offset, or the final guest frame joined with the virtual offset.
- R8: After a fault no further memory read is issued. `rsp_reads` equals the number of read handshakes made for that translation.
- R9: At most one read is outstanding. A read request keeps its address stable until `mem_req_ready` is high. Any response latency is tolerated.
- R10: `rsp_valid` is high for exactly one cycle per accepted request.
- R11: Synchronous active-high reset returns the walker to idle. After reset, `rsp_valid` and `mem_req_valid` are low and the read count is 0. A read that was pending when reset arrived is abandoned.
- R12: Both root registers are sampled when a request is accepted. A change to them during a translation does not affect that translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_gva | input | ADDR_W | Guest virtual address to translate |
| guest_root | input | ADDR_W | Guest-physical address of the guest first-level table |
| host_root | input | ADDR_W | Machine address of the host first-level table |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Machine address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | ADDR_W | Table entry read from memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 guest fault, 2 host fault |
| rsp_addr | output | ADDR_W | Machine address, faulting guest virtual or guest-physical address |
| rsp_reads | output | CNT_W | Reads used by this translation |

## Verification
The bound checker watches properties on every cycle:
- the busy-versus-ready relation;
- the single outstanding read and the stable address while a request waits;
- the absence of reads outside a translation and during the response;
- the one-cycle response pulse;
- the equality between the reported read count and the handshakes it counted itself;
- the count, offset and address forms of ok and guest-fault responses.

Only the bench scenarios can show the parts that depend on table contents. These are the exact read address sequence of each walk, the machine address produced, which host walk faulted and with what guest-physical address, the rejection of an entry whose frame bits are set but whose present bit is clear, the use of sampled roots when the inputs change mid-walk, and recovery after a reset that lands during a pending read.

// File: rtl/nwalk_pkg.sv
package nwalk_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_HOST_L1_REQ,
        WS_HOST_L1_WAIT,
        WS_HOST_L2_REQ,
        WS_HOST_L2_WAIT,
        WS_GUEST_REQ,
        WS_GUEST_WAIT,
        WS_RESPOND
    } walk_state_t;

    // Which guest-physical address the current host walk resolves
    typedef enum logic [1:0] {
        PH_ROOT,
        PH_POINTER,
        PH_FINAL
    } walk_phase_t;

    typedef enum logic [1:0] {
        RS_OK          = 2'd0,
        RS_GUEST_FAULT = 2'd1,
        RS_HOST_FAULT  = 2'd2
    } resp_code_t;

endpackage

// File: rtl/nw_entry_addr.sv
module nw_entry_addr #(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 12,
    parameter int IDX_W    = 10,
    parameter int ENT_LOG2 = 2,
    localparam int FRAME_W = ADDR_W - OFF_W
)(
    input  logic [FRAME_W-1:0] base_frame,
    input  logic [IDX_W-1:0]   index,
    output logic [ADDR_W-1:0]  entry_addr
);

    logic [ADDR_W-1:0] base_bytes;
    logic [ADDR_W-1:0] index_bytes;

    assign base_bytes  = {base_frame, {OFF_W{1'b0}}};
    assign index_bytes = ADDR_W'({index, {ENT_LOG2{1'b0}}});
    assign entry_addr  = base_bytes + index_bytes;

endmodule

// File: rtl/nw_entry_decode.sv
module nw_entry_decode #(
    parameter int ENTRY_W  = 32,
    parameter int OFF_W    = 12,
    parameter int PRES_BIT = 0,
    localparam int FRAME_W = ENTRY_W - OFF_W
)(
    input  logic [ENTRY_W-1:0] entry,
    output logic               present,
    output logic [FRAME_W-1:0] frame
);

    logic unused_attr_bits;

    assign present          = entry[PRES_BIT];
    assign frame            = entry[ENTRY_W-1:OFF_W];
    assign unused_attr_bits = ^entry[OFF_W-1:0];

endmodule

// File: rtl/nw_read_ctr.sv
module nw_read_ctr #(
    parameter int CNT_W = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (bump && (count != {CNT_W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/nested_walker.sv
module nested_walker
    import nwalk_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 12,
    parameter int IDX_W    = 10,
    parameter int PRES_BIT = 0,
    localparam int FRAME_W   = ADDR_W - OFF_W,
    localparam int LEVELS    = 2,
    localparam int MAX_READS = (LEVELS + 1) * LEVELS + LEVELS,
    localparam int CNT_W     = $clog2(MAX_READS + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_gva,
    input  logic [ADDR_W-1:0] guest_root,
    input  logic [ADDR_W-1:0] host_root,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [CNT_W-1:0]  rsp_reads
);

    walk_state_t        state_q, state_n;
    walk_phase_t        phase_q;
    resp_code_t         code_q;
    logic [ADDR_W-1:0]  gva_q;
    logic [ADDR_W-1:0]  gpa_q;
    logic [ADDR_W-1:0]  result_q;
    logic [FRAME_W-1:0] hroot_frame_q;
    logic [FRAME_W-1:0] frame_q;

    logic               accept;
    logic               mem_fire;
    logic               ent_present;
    logic [FRAME_W-1:0] ent_frame;
    logic [FRAME_W-1:0] sel_base;
    logic [IDX_W-1:0]   sel_index;
    logic [ADDR_W-1:0]  sel_addr;
    logic               unused_root_low;

    assign accept          = req_valid && (state_q == WS_IDLE);
    assign mem_fire        = mem_req_valid && mem_req_ready;
    assign unused_root_low = ^host_root[OFF_W-1:0];

    nw_entry_decode #(
        .ENTRY_W (ADDR_W),
        .OFF_W   (OFF_W),
        .PRES_BIT(PRES_BIT)
    ) u_decode (
        .entry  (mem_rsp_data),
        .present(ent_present),
        .frame  (ent_frame)
    );

    nw_entry_addr #(
        .ADDR_W(ADDR_W),
        .OFF_W (OFF_W),
        .IDX_W (IDX_W)
    ) u_addr (
        .base_frame(sel_base),
        .index     (sel_index),
        .entry_addr(sel_addr)
    );

    nw_read_ctr #(
        .CNT_W(CNT_W)
    ) u_reads (
        .clk  (clk),
        .rst  (rst),
        .clear(accept),
        .bump (mem_fire),
        .count(rsp_reads)
    );

    // Table base and index for the read the current state issues
    always_comb begin
        sel_base  = frame_q;
        sel_index = gva_q[OFF_W +: IDX_W];
        unique case (state_q)
            WS_HOST_L1_REQ: begin
                sel_base  = hroot_frame_q;
                sel_index = gpa_q[ADDR_W-1 -: IDX_W];
            end
            WS_HOST_L2_REQ: begin
                sel_base  = frame_q;
                sel_index = gpa_q[OFF_W +: IDX_W];
            end
            WS_GUEST_REQ: begin
                sel_base  = frame_q;
                sel_index = (phase_q == PH_ROOT) ? gva_q[ADDR_W-1 -: IDX_W]
                                                 : gva_q[OFF_W +: IDX_W];
            end
            default: begin
                sel_base  = frame_q;
                sel_index = gva_q[OFF_W +: IDX_W];
            end
        endcase
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            WS_IDLE:         if (accept) state_n = WS_HOST_L1_REQ;
            WS_HOST_L1_REQ:  if (mem_req_ready) state_n = WS_HOST_L1_WAIT;
            WS_HOST_L1_WAIT: if (mem_rsp_valid) state_n = ent_present ? WS_HOST_L2_REQ : WS_RESPOND;
            WS_HOST_L2_REQ:  if (mem_req_ready) state_n = WS_HOST_L2_WAIT;
            WS_HOST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_present || (phase_q == PH_FINAL)) state_n = WS_RESPOND;
                    else                                       state_n = WS_GUEST_REQ;
                end
            end
            WS_GUEST_REQ:    if (mem_req_ready) state_n = WS_GUEST_WAIT;
            WS_GUEST_WAIT:   if (mem_rsp_valid) state_n = ent_present ? WS_HOST_L1_REQ : WS_RESPOND;
            WS_RESPOND:      state_n = WS_IDLE;
            default:         state_n = WS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= WS_IDLE;
        else     state_q <= state_n;
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q       <= PH_ROOT;
            code_q        <= RS_OK;
            gva_q         <= '0;
            gpa_q         <= '0;
            result_q      <= '0;
            hroot_frame_q <= '0;
            frame_q       <= '0;
        end else begin
            unique case (state_q)
                WS_IDLE: begin
                    if (accept) begin
                        gva_q         <= req_gva;
                        gpa_q         <= guest_root;
                        hroot_frame_q <= host_root[ADDR_W-1:OFF_W];
                        phase_q       <= PH_ROOT;
                    end
                end
                WS_HOST_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (ent_present) begin
                            frame_q <= ent_frame;
                        end else begin
                            code_q   <= RS_HOST_FAULT;
                            result_q <= gpa_q;
                        end
                    end
                end
                WS_HOST_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_present) begin
                            code_q   <= RS_HOST_FAULT;
                            result_q <= gpa_q;
                        end else if (phase_q == PH_FINAL) begin
                            code_q   <= RS_OK;
                            result_q <= {ent_frame, gva_q[OFF_W-1:0]};
                        end else begin
                            frame_q <= ent_frame;
                        end
                    end
                end
                WS_GUEST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_present) begin
                            code_q   <= RS_GUEST_FAULT;
                            result_q <= gva_q;
                        end else if (phase_q == PH_ROOT) begin
                            gpa_q   <= {ent_frame, {OFF_W{1'b0}}};
                            phase_q <= PH_POINTER;
                        end else begin
                            gpa_q   <= {ent_frame, gva_q[OFF_W-1:0]};
                            phase_q <= PH_FINAL;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == WS_IDLE);
        mem_req_valid = (state_q == WS_HOST_L1_REQ) || (state_q == WS_HOST_L2_REQ) ||
                        (state_q == WS_GUEST_REQ);
        mem_req_addr  = sel_addr;
        rsp_valid     = (state_q == WS_RESPOND);
        rsp_status    = code_q;
        rsp_addr      = result_q;
    end

endmodule

// File: rtl/nw_walk_checker.sv
module nw_walk_checker #(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 12,
    parameter int CNT_W     = 4,
    parameter int MAX_READS = 8
)(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_gva,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [CNT_W-1:0]  rsp_reads
);

    logic              busy_c;
    logic              outst_c;
    logic [CNT_W-1:0]  hs_c;
    logic [ADDR_W-1:0] gva_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_c  <= 1'b0;
            outst_c <= 1'b0;
            hs_c    <= '0;
            gva_c   <= '0;
        end else begin
            if (req_valid && req_ready) begin
                busy_c <= 1'b1;
                gva_c  <= req_gva;
                hs_c   <= '0;
            end else if (rsp_valid) begin
                busy_c <= 1'b0;
            end
            if (mem_req_valid && mem_req_ready) begin
                outst_c <= 1'b1;
                hs_c    <= hs_c + 1'b1;
            end else if (mem_rsp_valid) begin
                outst_c <= 1'b0;
            end
        end
    end

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        busy_c |-> !req_ready);

    a_r9_single_read: assert property (@(posedge clk) disable iff (rst)
        outst_c |-> !mem_req_valid);

    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_c |-> !mem_req_valid);

    a_r8_resp_quiet: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_req_valid);

    a_r8_count_match: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_reads == hs_c));

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r10_only_when_busy: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> busy_c);

    a_r7_code_range: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status != 2'd3));

    a_r5_ok_shape: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd0) |->
            (rsp_reads == CNT_W'(MAX_READS) && rsp_addr[OFF_W-1:0] == gva_c[OFF_W-1:0]));

    a_r6_guest_fault_shape: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd1) |->
            (rsp_addr == gva_c && (rsp_reads == CNT_W'(3) || rsp_reads == CNT_W'(6))));

endmodule

bind nested_walker nw_walk_checker #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .CNT_W    (CNT_W),
    .MAX_READS(MAX_READS)
) u_walk_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_gva      (req_gva),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .rsp_valid    (rsp_valid),
    .rsp_status   (rsp_status),
    .rsp_addr     (rsp_addr),
    .rsp_reads    (rsp_reads)
);

// File: tb/tb_nested_walker.sv
`timescale 1ns/1ps
module tb_nested_walker;

    localparam logic [31:0] HROOT_A     = 32'h0008_0000;
    localparam logic [31:0] HROOT_EMPTY = 32'h0009_0000;
    localparam logic [31:0] GROOT_A     = 32'h0000_3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_gva = '0;
    logic [31:0] guest_root = GROOT_A;
    logic [31:0] host_root = HROOT_A;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_addr;
    logic [3:0]  rsp_reads;

    always #4 clk = ~clk;

    nested_walker dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_gva(req_gva),
        .guest_root(guest_root), .host_root(host_root),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_addr(rsp_addr), .rsp_reads(rsp_reads)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [logic [31:0]];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    logic        rdy_q = 1'b0;
    logic        pend_q = 1'b0;
    logic [31:0] pend_addr = '0;
    int          lat_q = 0;
    logic        rsp_v_q = 1'b0;
    logic [31:0] rsp_d_q = '0;
    logic [31:0] log_addr [16];
    int          log_n = 0;

    assign mem_req_ready = rdy_q && !pend_q;
    assign mem_rsp_valid = rsp_v_q;
    assign mem_rsp_data  = rsp_d_q;

    always @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            rsp_v_q <= 1'b0;
            rdy_q   <= 1'b0;
        end else begin
            rdy_q   <= ($urandom % 4) != 0;
            rsp_v_q <= 1'b0;
            if (req_valid && req_ready) log_n <= 0;
            if (mem_req_valid && mem_req_ready) begin
                pend_q    <= 1'b1;
                pend_addr <= mem_req_addr;
                lat_q     <= int'($urandom % 5);
                if (log_n < 16) log_addr[log_n] <= mem_req_addr;
                log_n <= log_n + 1;
            end else if (pend_q) begin
                if (lat_q == 0) begin
                    rsp_v_q <= 1'b1;
                    rsp_d_q <= rd(pend_addr);
                    pend_q  <= 1'b0;
                end else begin
                    lat_q <= lat_q - 1;
                end
            end
        end
    end

    // ---------------- table building ----------------
    int unsigned host_pool  = 32'h200;
    int unsigned guest_pool = 32'h10;

    function automatic logic [19:0] gm(input logic [19:0] g);
        return g + 20'h40000;
    endfunction

    task automatic hmap(input logic [19:0] g);
        logic [31:0] a;
        logic [19:0] l2;
        a = HROOT_A + {20'h0, g[19:10], 2'b00};
        if (!rd(a)[0]) begin
            mem[a] = {host_pool[19:0], 12'h001};
            host_pool++;
        end
        l2 = rd(a)[31:12];
        mem[{l2, 12'h000} + {20'h0, g[9:0], 2'b00}] = {gm(g), 12'h001};
    endtask

    function automatic logic [31:0] grd(input logic [31:0] gpa);
        return rd({gm(gpa[31:12]), gpa[11:0]});
    endfunction

    task automatic gwrite(input logic [31:0] gpa, input logic [31:0] v);
        mem[{gm(gpa[31:12]), gpa[11:0]}] = v;
    endtask

    task automatic gmap(input logic [19:0] vpn, input logic [19:0] gf);
        logic [31:0] a;
        logic [19:0] l2;
        a = GROOT_A + {20'h0, vpn[19:10], 2'b00};
        if (!grd(a)[0]) begin
            hmap(guest_pool[19:0]);
            gwrite(a, {guest_pool[19:0], 12'h001});
            guest_pool++;
        end
        l2 = grd(a)[31:12];
        gwrite({l2, 12'h000} + {20'h0, vpn[9:0], 2'b00}, {gf, 12'h001});
    endtask

    // ---------------- reference walk ----------------
    logic [31:0] exp_log [16];
    int          exp_n;

    task automatic host_ref(input logic [31:0] gpa, input logic [31:0] hroot,
                            output bit ok, output logic [19:0] mfr);
        logic [31:0] a, e;
        ok = 0; mfr = '0;
        a = {hroot[31:12], 12'h000} + {20'h0, gpa[31:22], 2'b00};
        exp_log[exp_n] = a; exp_n++;
        e = rd(a);
        if (!e[0]) return;
        a = {e[31:12], 12'h000} + {20'h0, gpa[21:12], 2'b00};
        exp_log[exp_n] = a; exp_n++;
        e = rd(a);
        if (!e[0]) return;
        ok = 1; mfr = e[31:12];
    endtask

    task automatic ref_walk(input logic [31:0] gva, input logic [31:0] groot,
                            input logic [31:0] hroot,
                            output logic [1:0] st, output logic [31:0] ad);
        bit ok;
        logic [19:0] mfr;
        logic [31:0] gpa, a, e;
        exp_n = 0;
        gpa = groot;
        for (int lvl = 0; lvl < 2; lvl++) begin
            host_ref(gpa, hroot, ok, mfr);
            if (!ok) begin st = 2'd2; ad = gpa; return; end
            a = {mfr, 12'h000} + {20'h0, (lvl == 0) ? gva[31:22] : gva[21:12], 2'b00};
            exp_log[exp_n] = a; exp_n++;
            e = rd(a);
            if (!e[0]) begin st = 2'd1; ad = gva; return; end
            gpa = (lvl == 0) ? {e[31:12], 12'h000} : {e[31:12], gva[11:0]};
        end
        host_ref(gpa, hroot, ok, mfr);
        if (!ok) begin st = 2'd2; ad = gpa; return; end
        st = 2'd0; ad = {mfr, gva[11:0]};
    endtask

    // ---------------- one translation ----------------
    logic [1:0]  act_st;
    logic [31:0] act_ad;
    logic [3:0]  act_rd;

    task automatic xlate(input logic [31:0] gva, input bit hold, input bit swap,
                         input string tag);
        logic [1:0]  es;
        logic [31:0] ea;
        string       rq;
        int          cyc;
        bit          seq_ok;
        ref_walk(gva, guest_root, host_root, es, ea);
        rq = (es == 2'd0) ? "R5" : (es == 2'd1) ? "R6" : "R7";
        @(negedge clk);
        req_gva = gva; req_valid = 1'b1;
        @(negedge clk);
        if (hold) req_gva = ~gva; else req_valid = 1'b0;
        if (swap) begin guest_root = 32'hDEAD_0000; host_root = HROOT_EMPTY; end
        chk(req_ready == 1'b0, "R1", {tag, " ready low while busy"}, {31'h0, req_ready}, 32'h0);
        cyc = 0;
        while (!rsp_valid && cyc < 400) begin @(negedge clk); cyc++; end
        if (!rsp_valid) begin
            chk(1'b0, "R10", {tag, " watchdog no response"}, 32'h0, 32'h1);
            return;
        end
        act_st = rsp_status; act_ad = rsp_addr; act_rd = rsp_reads;
        req_valid = 1'b0;
        guest_root = GROOT_A; host_root = HROOT_A;
        chk(act_st == es, rq, {tag, " status"}, {30'h0, act_st}, {30'h0, es});
        chk(act_ad == ea, rq, {tag, " address"}, act_ad, ea);
        chk(int'(act_rd) == exp_n, "R8", {tag, " read count"}, {28'h0, act_rd}, exp_n);
        chk(log_n == int'(act_rd), "R9", {tag, " handshakes vs count"}, log_n, {28'h0, act_rd});
        seq_ok = (log_n == exp_n);
        for (int i = 0; i < exp_n && i < 16; i++)
            if (log_addr[i] != exp_log[i]) seq_ok = 0;
        chk(seq_ok, "R3/R4", {tag, " read address order"}, log_n, exp_n);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", {tag, " pulse one cycle"}, {31'h0, rsp_valid}, 32'h0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- main ----------------
    logic [19:0] vlist [24];

    initial begin
        void'($urandom(32'd20240611));
        hmap(GROOT_A[31:12]);
        gmap(20'h00401, 20'h01234); hmap(20'h01234);
        gwrite(GROOT_A + {20'h0, 10'h3FF, 2'b00}, {20'hEEEEE, 12'h001});
        gwrite(GROOT_A + {20'h0, 10'h1FE, 2'b00}, {20'h00011, 12'h000});
        gmap(20'h00805, 20'h01FFF);

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R11 reset state
        chk(req_ready && !rsp_valid && !mem_req_valid && rsp_reads == 0, "R11",
            "state after reset", {req_ready, rsp_valid, mem_req_valid, 25'h0, rsp_reads}, 32'h8000_0000);

        // R5 direct success
        xlate(32'h0040_1ABC, 0, 0, "D1");
        chk(act_st == 0 && act_rd == 8 && act_ad == 32'h4123_4ABC, "R5", "D1 literal",
            act_ad, 32'h4123_4ABC);
        // R6 first-level guest miss
        xlate(32'h7FC0_1000, 0, 0, "D2");
        chk(act_st == 1 && act_rd == 3 && act_ad == 32'h7FC0_1000, "R6", "D2 literal",
            {28'h0, act_rd}, 32'h3);
        // R6 second-level guest miss
        xlate(32'h0040_2123, 0, 0, "D3");
        chk(act_st == 1 && act_rd == 6, "R6", "D3 literal", {28'h0, act_rd}, 32'h6);
        // R7 host fault on the guest root
        host_root = HROOT_EMPTY;
        xlate(32'h0040_1ABC, 0, 0, "D4");
        chk(act_st == 2 && act_rd == 1 && act_ad == GROOT_A, "R7", "D4 literal", act_ad, GROOT_A);
        // R7 host fault on guest table pointer
        xlate(32'hFFC0_5555, 0, 0, "D5");
        chk(act_st == 2 && act_rd == 4 && act_ad == 32'hEEEE_E000, "R7", "D5 literal",
            act_ad, 32'hEEEE_E000);
        // R7 host fault on final frame, host first level
        xlate(32'h0080_5321, 0, 0, "D6");
        chk(act_st == 2 && act_rd == 7 && act_ad == 32'h01FF_F321, "R7", "D6 literal",
            act_ad, 32'h01FF_F321);
        // R7 host fault on final frame, host second level
        hmap(20'h01C00); gmap(20'h00806, 20'h01C01);
        xlate(32'h0080_6777, 0, 0, "D7");
        chk(act_st == 2 && act_rd == 8 && act_ad == 32'h01C0_1777, "R7", "D7 literal",
            act_ad, 32'h01C0_1777);
        // R2 frame bits set but present clear
        xlate(32'h7F80_0444, 0, 0, "D8");
        chk(act_st == 1 && act_rd == 3, "R2", "D8 not-present entry", {28'h0, act_rd}, 32'h3);
        // R1 request held during walk is ignored
        xlate(32'h0040_1ABC, 1, 0, "D9");
        chk(act_ad == 32'h4123_4ABC, "R1", "D9 held request ignored", act_ad, 32'h4123_4ABC);
        // R12 roots changed mid-walk
        xlate(32'h0040_1ABC, 0, 1, "D10");
        chk(act_st == 0 && act_ad == 32'h4123_4ABC, "R12", "D10 roots sampled", act_ad,
            32'h4123_4ABC);

        // R11 reset during a pending read
        @(negedge clk); req_gva = 32'h0040_1ABC; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(req_ready && !rsp_valid && !mem_req_valid && rsp_reads == 0, "R11",
            "state after mid-walk reset", {req_ready, rsp_valid, mem_req_valid, 29'h0}, 32'h8000_0000);
        begin
            bit quiet = 1;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (mem_req_valid || rsp_valid) quiet = 0;
            end
            chk(quiet, "R11", "no activity after reset", {31'h0, quiet}, 32'h1);
        end
        xlate(32'h0040_1ABC, 0, 0, "D11");
        chk(act_st == 0 && act_rd == 8, "R11", "recovery after reset", {28'h0, act_rd}, 32'h8);

        // Random tables and addresses
        for (int i = 0; i < 24; i++) begin
            logic [19:0] vpn, gf;
            vpn = {10'(($urandom % 6) + 1), 10'($urandom)};
            gf  = 20'(($urandom % 32'h300) + 32'h1000);
            gmap(vpn, gf);
            if (($urandom % 4) != 0) hmap(gf);
            vlist[i] = vpn;
        end
        for (int n = 0; n < 60; n++) begin
            int r;
            logic [31:0] g;
            r = int'($urandom % 10);
            if (r < 6)      g = {vlist[$urandom % 24], 12'($urandom)};
            else if (r < 8) g = {10'(($urandom % 6) + 1), 22'($urandom)};
            else            g = $urandom;
            xlate(g, ($urandom % 5) == 0, ($urandom % 7) == 0, $sformatf("RND%0d", n));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule